// File: doc/BRIEF.md
# Requester-Aware System Address Decoder

This block sorts a 32-bit physical address into one of three outcomes: DRAM, on-chip SRAM, or unmapped. The outcome depends on the address, on which kind of master issued the request, and on a small set of configuration registers that software writes at run time. Two kinds of master are distinguished. The processor class covers the CPU and its coherent port. The other class covers every remaining master. The same address can therefore land in DRAM, in on-chip SRAM, or nowhere, depending on who asks.

The on-chip SRAM is 256 KB, split into four 64 KB quarters. Each quarter is placed near the top of the address space or at the bottom, independently of the others. The processor class additionally passes through a coherency-unit filter. The filter is described by an enable pair and a start/end window with 1 MB granularity. Only processor-class requests inside that window reach DRAM, and inside the lowest megabyte the window also exposes an alias of the high SRAM. Each request gives a registered response one cycle later: a target code, the byte offset inside the chosen memory, and an error flag.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset, `rsp_vld` is low and the configuration holds: all four quarters high, unit and filter enabled, window start 0x000 and window end 0xFFE (units of 1 MB).
- R2: A request with `req_vld` high at a clock edge produces `rsp_vld` high after that edge. `rsp_vld` is low after every edge without a request.
- R3: An address at or above 0xFFFC_0000 selects quarter `addr[17:16]`. It decodes to SRAM (target 2) with offset `addr[17:0]` when that quarter's placement bit is 1, and to unmapped otherwise. This holds for both classes.
- R4: An address below 0x0004_0000 whose quarter `addr[17:16]` has its placement bit at 0 decodes to SRAM with offset `addr[17:0]` for both classes. This takes priority over DRAM.
- R5: For the other-master class (`req_cpu`=0), addresses in [0x0010_0000, 0x4000_0000) decode to DRAM (target 1) with offset equal to the address. The rest of the lowest megabyte that R4 does not claim is unmapped.
- R6: For the processor class with unit and filter both enabled, an address below 0x4000_0000 that R4 does not claim is DRAM only if it lies in [start×1 MB, end×1 MB). Outside that window it is unmapped, except as stated in R7.
- R7: For the processor class with filtering active, an address in [0x000C_0000, 0x0010_0000) that lies inside the window decodes to SRAM with offset `addr[17:0]` when quarter `addr[17:16]` is placed high, and to unmapped otherwise.
- R8: If either control bit is 0 (bit 0 is the unit enable, bit 1 is the filter enable), the processor class decodes exactly like the other-master class.
- R9: Bits 19:0 of a window start or end write are ignored.
- R10: A write (`cfg_we`, with `cfg_sel` 0 = quarter placement in bits 3:0, 1 = control in bits 1:0, 2 = window start in bits 31:20, 3 = window end in bits 31:20) changes decoding from the next edge on. A request on the same edge as the write uses the old value.
- R11: Addresses in [0x4000_0000, 0xFFFC_0000) are unmapped for both classes.
- R12: `rsp_err` is 1 exactly when the target is unmapped (target 0), and the offset is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_vld | input | 1 | Decode request valid |
| req_addr | input | 32 | Physical address to decode |
| req_cpu | input | 1 | 1 = processor class, 0 = other master |
| rsp_vld | output | 1 | Response valid |
| rsp_tgt | output | 2 | Target: 0 unmapped, 1 DRAM, 2 SRAM |
| rsp_off | output | 32 | Byte offset inside the target |
| rsp_err | output | 1 | Decode error |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle response timing;
- the absence of spurious responses;
- the unconditional hole between 1 GB and the SRAM top region;
- offset ranges per target;
- the other-master rejection in the low megabyte;
- the fact that the SRAM top region never yields DRAM.

The cases that depend on the configuration can only be shown by the bench scenarios against its reference model. These cases are:
- quarter placement priority;
- the window edges;
- the alias and its dependence on placement;
- disabling the filter;
- ignored low bits;
- the exact cycle at which a write takes effect.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int AW        = 32;               // address width
    localparam int NQ        = 4;                // SRAM quarters
    localparam int QB        = 16;               // log2 quarter size
    localparam int QSEL_W    = $clog2(NQ);
    localparam int SRAM_W    = QB + QSEL_W;      // log2 SRAM size
    localparam int WINB      = 20;               // log2 window granule
    localparam int WIN_W     = AW - WINB;
    localparam int DRAM_W    = 30;               // log2 DRAM span
    localparam int CTRL_W    = 2;
    localparam int SEL_W     = 2;

    localparam logic [AW-1:0] SRAM_TOP_BASE = {AW{1'b1}} << SRAM_W;
    localparam logic [AW-1:0] ALIAS_BASE    = (AW'(1) << WINB) - (AW'(1) << SRAM_W);

    localparam logic [NQ-1:0]    RST_PLACE = {NQ{1'b1}};
    localparam logic [WIN_W-1:0] RST_WLO   = '0;
    localparam logic [WIN_W-1:0] RST_WHI   = {{(WIN_W-1){1'b1}}, 1'b0};

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_SRAM = 2'd2
    } tgt_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_PLACE = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_WLO   = 2'd2,
        SEL_WHI   = 2'd3
    } sel_e;

    typedef struct packed {
        logic [NQ-1:0]    place_hi;
        logic             unit_en;
        logic             filt_en;
        logic [WIN_W-1:0] win_lo;
        logic [WIN_W-1:0] win_hi;
    } amap_cfg_t;

    typedef struct packed {
        logic top_region;
        logic top_hit;
        logic low_hit;
        logic alias_ok;
    } sram_hit_t;

    typedef struct packed {
        tgt_e          tgt;
        logic [AW-1:0] off;
    } dec_t;

    function automatic logic [WIN_W-1:0] granule(input logic [AW-1:0] a);
        return a[AW-1:WINB];
    endfunction

endpackage

// File: rtl/amap_cfg_regs.sv
module amap_cfg_regs
    import amap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [AW-1:0]         wdata,
    output amap_cfg_t             cfg
);

    amap_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.place_hi <= RST_PLACE;
            cfg_q.unit_en  <= 1'b1;
            cfg_q.filt_en  <= 1'b1;
            cfg_q.win_lo   <= RST_WLO;
            cfg_q.win_hi   <= RST_WHI;
        end else if (we) begin
            case (sel_e'(sel))
                SEL_PLACE: cfg_q.place_hi <= wdata[NQ-1:0];
                SEL_CTRL: begin
                    cfg_q.unit_en <= wdata[0];
                    cfg_q.filt_en <= wdata[1];
                end
                SEL_WLO:   cfg_q.win_lo <= granule(wdata);
                SEL_WHI:   cfg_q.win_hi <= granule(wdata);
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/amap_sram_map.sv
module amap_sram_map
    import amap_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [NQ-1:0] place_hi,
    output sram_hit_t     hit
);

    logic [QSEL_W-1:0] qidx;
    logic [NQ-1:0]     q_hi;
    logic [NQ-1:0]     q_lo;

    assign qidx = addr[SRAM_W-1:QB];

    for (genvar i = 0; i < NQ; i++) begin : g_quarter
        assign q_hi[i] = place_hi[i]  && (qidx == QSEL_W'(i));
        assign q_lo[i] = !place_hi[i] && (qidx == QSEL_W'(i));
    end

    always_comb begin
        hit.top_region = (addr[AW-1:SRAM_W] == SRAM_TOP_BASE[AW-1:SRAM_W]);
        hit.alias_ok   = |q_hi;
        hit.top_hit    = hit.top_region && (|q_hi);
        hit.low_hit    = (addr[AW-1:SRAM_W] == '0) && (|q_lo);
    end

endmodule

// File: rtl/amap_filter_win.sv
module amap_filter_win
    import amap_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  amap_cfg_t     cfg,
    output logic          filt_on,
    output logic          in_win
);

    logic [WIN_W-1:0] g;

    assign g       = granule(addr);
    assign filt_on = cfg.unit_en && cfg.filt_en;
    assign in_win  = (g >= cfg.win_lo) && (g < cfg.win_hi);

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import amap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_vld,
    input  logic [31:0]       req_addr,
    input  logic              req_cpu,
    output logic              rsp_vld,
    output logic [1:0]        rsp_tgt,
    output logic [31:0]       rsp_off,
    output logic              rsp_err
);

    amap_cfg_t cfg;
    sram_hit_t sh;
    logic      filt_on;
    logic      in_win;
    logic      dram_span;
    logic      low_mb;
    logic      alias_zone;
    dec_t      dec;

    amap_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    amap_sram_map u_sram (
        .addr     (req_addr),
        .place_hi (cfg.place_hi),
        .hit      (sh)
    );

    amap_filter_win u_win (
        .addr    (req_addr),
        .cfg     (cfg),
        .filt_on (filt_on),
        .in_win  (in_win)
    );

    assign dram_span  = (req_addr[AW-1:DRAM_W] == '0);
    assign low_mb     = (granule(req_addr) == '0);
    assign alias_zone = low_mb && (req_addr >= ALIAS_BASE);

    always_comb begin
        dec.tgt = TGT_NONE;
        if (sh.top_region) begin
            if (sh.top_hit) dec.tgt = TGT_SRAM;
        end else if (sh.low_hit) begin
            dec.tgt = TGT_SRAM;
        end else if (dram_span) begin
            if (req_cpu && filt_on) begin
                if (in_win) begin
                    if (alias_zone) dec.tgt = sh.alias_ok ? TGT_SRAM : TGT_NONE;
                    else            dec.tgt = TGT_DRAM;
                end
            end else if (!low_mb) begin
                dec.tgt = TGT_DRAM;
            end
        end
        case (dec.tgt)
            TGT_SRAM: dec.off = AW'(req_addr[SRAM_W-1:0]);
            TGT_DRAM: dec.off = AW'(req_addr[DRAM_W-1:0]);
            default:  dec.off = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            rsp_tgt <= TGT_NONE;
            rsp_off <= '0;
            rsp_err <= 1'b0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_tgt <= dec.tgt;
                rsp_off <= dec.off;
                rsp_err <= (dec.tgt == TGT_NONE);
            end
        end
    end

endmodule

// File: rtl/addr_map_decoder_chk.sv
module addr_map_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_vld,
    input logic [31:0] req_addr,
    input logic        req_cpu,
    input logic        rsp_vld,
    input logic [1:0]  rsp_tgt,
    input logic [31:0] rsp_off,
    input logic        rsp_err
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !rsp_vld);

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld);

    assert_top_not_dram_R3: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_addr >= 32'hFFFC_0000) |=> (rsp_tgt != 2'd1));

    assert_sram_off_range_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_tgt == 2'd2) |-> (rsp_off < 32'h0004_0000));

    assert_dram_off_range_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_tgt == 2'd1) |-> (rsp_off[31:30] == 2'b00));

    assert_other_low_mb_R5: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_cpu && req_addr >= 32'h0004_0000 && req_addr < 32'h0010_0000)
        |=> rsp_err);

    assert_gap_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_addr >= 32'h4000_0000 && req_addr < 32'hFFFC_0000) |=> rsp_err);

    assert_err_zero_off_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_err) |-> (rsp_off == 32'd0));

endmodule

bind addr_map_decoder addr_map_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .req_cpu  (req_cpu),
    .rsp_vld  (rsp_vld),
    .rsp_tgt  (rsp_tgt),
    .rsp_off  (rsp_off),
    .rsp_err  (rsp_err)
);

// File: tb/sim_addr_map_decoder.sv
`timescale 1ns/1ps
module sim_addr_map_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        req_cpu = 1'b0;
    logic        rsp_vld;
    logic [1:0]  rsp_tgt;
    logic [31:0] rsp_off;
    logic        rsp_err;

    always #2.5 clk = ~clk;

    addr_map_decoder u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_vld(req_vld), .req_addr(req_addr), .req_cpu(req_cpu),
        .rsp_vld(rsp_vld), .rsp_tgt(rsp_tgt), .rsp_off(rsp_off), .rsp_err(rsp_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // reference configuration
    logic [3:0]      m_place;
    logic            m_unit, m_filt;
    longint unsigned m_lo, m_hi;

    logic        e_vld = 0;
    logic [1:0]  e_tgt = 0;
    logic [31:0] e_off = 0;
    string       e_tag = "R1";

    task automatic model_reset();
        m_place = 4'hF; m_unit = 1; m_filt = 1; m_lo = 0; m_hi = 64'hFFE;
    endtask

    function automatic void ref_dec(input logic [31:0] a, input logic cpu,
                                    output logic [1:0] t, output logic [31:0] o);
        longint unsigned la = a;
        int unsigned q;
        t = 0; o = 0;
        if (la >= 64'hFFFC_0000) begin
            q = int'((la - 64'hFFFC_0000) / 65536);
            if (m_place[q]) begin t = 2; o = 32'(la - 64'hFFFC_0000); end
        end else if (la < 64'h4_0000 && !m_place[int'(la / 65536)]) begin
            t = 2; o = a;
        end else if (la < 64'h4000_0000) begin
            if (cpu && m_unit && m_filt) begin
                if (la >= m_lo * 1048576 && la < m_hi * 1048576) begin
                    if (la >= 64'hC_0000 && la < 64'h10_0000) begin
                        q = int'((la - 64'hC_0000) / 65536);
                        if (m_place[q]) begin t = 2; o = 32'(la - 64'hC_0000); end
                    end else begin
                        t = 1; o = a;
                    end
                end
            end else if (la >= 64'h10_0000) begin
                t = 1; o = a;
            end
        end
    endfunction

    task automatic check();
        n_chk++;
        if (rsp_vld !== e_vld) begin
            n_fail++;
            $display("FAIL %s: rsp_vld actual %0b expected %0b", e_tag, rsp_vld, e_vld);
        end else if (e_vld) begin
            if (rsp_tgt !== e_tgt || rsp_off !== e_off || rsp_err !== (e_tgt == 2'd0)) begin
                n_fail++;
                $display("FAIL %s: tgt/off/err actual %0d/%h/%0b expected %0d/%h/%0b",
                         e_tag, rsp_tgt, rsp_off, rsp_err, e_tgt, e_off, (e_tgt == 2'd0));
            end
        end
    endtask

    task automatic cyc(input logic v, input logic [31:0] a, input logic cpu,
                       input logic we, input logic [1:0] sel, input logic [31:0] wd,
                       input string tag);
        logic [1:0]  t;
        logic [31:0] o;
        @(negedge clk);
        check();
        req_vld = v; req_addr = a; req_cpu = cpu;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        ref_dec(a, cpu, t, o);
        e_vld = v; e_tgt = t; e_off = o; e_tag = tag;
        if (we) begin
            case (sel)
                2'd0: m_place = wd[3:0];
                2'd1: begin m_unit = wd[0]; m_filt = wd[1]; end
                2'd2: m_lo = longint'(wd[31:20]);
                default: m_hi = longint'(wd[31:20]);
            endcase
        end
    endtask

    task automatic rq(input logic [31:0] a, input logic cpu, input string tag);
        cyc(1, a, cpu, 0, 2'd0, 32'd0, tag);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
        cyc(0, 32'd0, 0, 1, sel, d, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        model_reset();
        rst = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check();                          // R1: idle during reset
        end
        rst = 0;
        // R1 defaults visible through decoding
        rq(32'h0000_0000, 1, "R1");
        rq(32'h0000_0000, 0, "R1");
        rq(32'h000C_0000, 1, "R1");
        rq(32'hFFFC_0010, 0, "R1");
        cyc(0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, "R2");
        // R3 / R4 / R7 with quarter 2 moved low
        wr(2'd0, 32'h0000_000B, "R10");
        rq(32'hFFFE_0004, 1, "R3");
        rq(32'hFFFF_0008, 0, "R3");
        rq(32'h0002_0004, 0, "R4");
        rq(32'h0002_0004, 1, "R4");
        rq(32'h0001_0000, 1, "R4");
        rq(32'h0003_FFFC, 0, "R4");
        rq(32'h000E_0000, 1, "R7");
        rq(32'h000D_0000, 1, "R7");
        // R5 other-master DRAM span
        rq(32'h0010_0000, 0, "R5");
        rq(32'h3FFF_FFFC, 0, "R5");
        rq(32'h0008_0000, 0, "R5");
        // R11 hole
        rq(32'h4000_0000, 1, "R11");
        rq(32'hFFFB_FFFC, 0, "R11");
        rq(32'h8000_0000, 1, "R11");
        // R6 / R9 narrowed window, low bits of writes ignored
        wr(2'd2, 32'h2001_2345, "R9");
        wr(2'd3, 32'h300F_FFFF, "R9");
        rq(32'h1FFF_FFFC, 1, "R6");
        rq(32'h2000_0000, 1, "R6");
        rq(32'h2FFF_FFFC, 1, "R6");
        rq(32'h3000_0000, 1, "R6");
        rq(32'h3000_0000, 0, "R6");
        // R10 same-edge write sees old window, next request sees new
        cyc(1, 32'h2800_0000, 1, 1, 2'd3, 32'h2500_0000, "R10");
        rq(32'h2800_0000, 1, "R10");
        // R8 filter disabled either way
        wr(2'd1, 32'h0000_0001, "R8");
        rq(32'h1000_0000, 1, "R8");
        rq(32'h0000_0000, 1, "R8");
        rq(32'h000D_0000, 1, "R8");
        wr(2'd1, 32'h0000_0002, "R8");
        rq(32'h1000_0000, 1, "R8");
        wr(2'd1, 32'h0000_0003, "R8");
        // R9 raised start to one granule hides lowest MB from the processor
        wr(2'd3, 32'hFFE0_0000, "R9");
        wr(2'd2, 32'h0010_FFFF, "R9");
        rq(32'h0000_0000, 1, "R9");
        rq(32'h000D_0000, 1, "R9");
        rq(32'h0010_0000, 1, "R9");
        rq(32'h0002_0000, 1, "R4");
        // R12 unmapped offset zero, quarter back high
        wr(2'd0, 32'h0000_000F, "R12");
        rq(32'h0002_0000, 0, "R12");
        rq(32'hFFFD_1234, 1, "R12");
        cyc(0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, "R2");
        @(negedge clk);
        check();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(500_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule